// File: doc/BRIEF.md
# Compare Timer with Downcount View

This block is a virtual timer that watches a free-running 64-bit count input and compares it against a 64-bit compare register. When the timer is enabled and the count has reached the compare value, a status flag is set. If the flag is not masked, a level interrupt output goes high.

Software reaches the timer through a small register bus. The bus has a write strobe, a read strobe and a word address. There are separate words for the control bits, for each 32-bit half of the compare value, and for a signed 32-bit "time remaining" view. Writing the remaining-time view moves the compare value to the current count plus the written value. This lets software treat the timer as a downcounter, while the count itself keeps running. Reading the view returns the distance left to expiry. Read data is registered and appears one clock after the read strobe.

Top module: `cmp_downcount_timer`

## Requirements
- R1: A synchronous active-high reset clears the enable and mask bits and the whole compare value, drives the interrupt low and clears the read data.
- R2: Control word at address 0 holds enable in bit 0 and mask in bit 1. Bit 2 reads back the fire status and ignores writes. Bits above 2 read as zero.
- R3: The compare value is written and read as two 32-bit halves, low half at address 1 and high half at address 2.
- R4: A write to address 3 sets the compare value to the count sampled in the write cycle plus the written word sign-extended to 64 bits, with the sum wrapping modulo 2^64.
- R5: A read of address 3 returns the low 32 bits of (compare value minus count), both when enabled and when disabled.
- R6: While enabled, status becomes 1 one clock after the count is greater than or equal to the compare value, using an unsigned 64-bit comparison, equality included.
- R7: While disabled, status reads 0 whatever the count and compare values are.
- R8: The interrupt output equals enable AND status AND NOT mask, taken from a register, so it follows a change of count or registers one clock later.
- R9: Read data is registered: it updates on the clock edge that samples the read strobe and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | 64 | Free-running count value |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, registered |

## Verification
The assertions assume that the reset is held high from time zero through at least one clock edge. They also assume that the count and the bus inputs are settled, with no X values, once reset has been released. The write-view check also assumes that a single write strobe targets exactly one address. The bench changes every input only on the falling clock edge and keeps reset asserted from the start. It issues no more than one bus operation per cycle. The count input is driven with chosen values, not with a running counter, so that each comparison case is exact and can be repeated.

// File: rtl/cmptmr_pkg.sv
package cmptmr_pkg;

  typedef struct packed {
    logic mask;
    logic en;
  } tmr_ctrl_t;

  localparam int unsigned CTL_EN_POS   = 0;
  localparam int unsigned CTL_MASK_POS = 1;
  localparam int unsigned CTL_STAT_POS = 2;

endpackage

// File: rtl/cmptmr_regs.sv
module cmptmr_regs
  import cmptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [CNT_W-1:0] cnt_i,
  output tmr_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] cmp_o
);

  localparam int unsigned NW        = CNT_W / DW;
  localparam int unsigned VIEW_ADDR = NW + 1;
  localparam int unsigned EXT_W     = CNT_W - DW;

  tmr_ctrl_t        ctrl_q;
  logic [DW-1:0]    cmp_w [NW];
  logic [CNT_W-1:0] cmp_rel;
  logic             view_we;
  logic             ctrl_we;

  assign view_we = wr_en && (addr == AW'(VIEW_ADDR));
  assign ctrl_we = wr_en && (addr == AW'(0));
  assign cmp_rel = cnt_i + {{EXT_W{wdata[DW-1]}}, wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.en   <= wdata[CTL_EN_POS];
      ctrl_q.mask <= wdata[CTL_MASK_POS];
    end
  end

  generate
    for (genvar w = 0; w < NW; w++) begin : g_cmp_word
      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_w[w] <= '0;
        end else if (view_we) begin
          cmp_w[w] <= cmp_rel[w*DW +: DW];
        end else if (wr_en && (addr == AW'(w + 1))) begin
          cmp_w[w] <= wdata;
        end
      end
      assign cmp_o[w*DW +: DW] = cmp_w[w];
    end
  endgenerate

  assign ctrl_o = ctrl_q;

  // R4
  view_wr_chk: assert property (@(posedge clk) disable iff (rst)
    view_we |=> (cmp_o == $past(cnt_i) + {{EXT_W{$past(wdata[DW-1])}}, $past(wdata)}));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(ctrl_o));

  // R3
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cmp_o));

endmodule

// File: rtl/cmptmr_cond.sv
module cmptmr_cond
  import cmptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_ctrl_t        ctrl_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             status_o,
  output logic             irq_o
);

  logic reached;
  logic status_q;
  logic irq_q;

  assign reached = ctrl_i.en && (cnt_i >= cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= reached;
      irq_q    <= reached && !ctrl_i.mask;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R7
  stat_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i.en |=> !status_q);

  // R8
  irq_stat_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (status_q && !$past(ctrl_i.mask)));

  // R6
  fire_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.en && !(cnt_i < cmp_i)) |=> status_q);

endmodule

// File: rtl/cmptmr_rdmux.sv
module cmptmr_rdmux
  import cmptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  tmr_ctrl_t        ctrl_i,
  input  logic             status_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [DW-1:0]    rdata_o
);

  localparam int unsigned NW        = CNT_W / DW;
  localparam int unsigned VIEW_ADDR = NW + 1;

  logic [CNT_W-1:0] remain;
  logic [DW-1:0]    sel;
  logic [DW-1:0]    rdata_q;

  assign remain = cmp_i - cnt_i;

  always_comb begin
    sel = '0;
    if (addr == AW'(0)) begin
      sel[CTL_EN_POS]   = ctrl_i.en;
      sel[CTL_MASK_POS] = ctrl_i.mask;
      sel[CTL_STAT_POS] = status_i;
    end else if (addr == AW'(VIEW_ADDR)) begin
      sel = remain[DW-1:0];
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (addr == AW'(w + 1)) sel = cmp_i[w*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= sel;
    end
  end

  assign rdata_o = rdata_q;

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));

  // R2
  ctl_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(0)) |=> (rdata_q[DW-1:CTL_STAT_POS+1] == '0));

endmodule

// File: rtl/cmp_downcount_timer.sv
module cmp_downcount_timer
  import cmptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);

  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] cmp;
  logic             status;

  cmptmr_regs #(.CNT_W(CNT_W), .DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .cnt_i  (cnt_i),
    .ctrl_o (ctrl),
    .cmp_o  (cmp)
  );

  cmptmr_cond #(.CNT_W(CNT_W)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .ctrl_i   (ctrl),
    .cmp_i    (cmp),
    .cnt_i    (cnt_i),
    .status_o (status),
    .irq_o    (irq)
  );

  cmptmr_rdmux #(.CNT_W(CNT_W), .DW(DW), .AW(AW)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .ctrl_i   (ctrl),
    .status_i (status),
    .cmp_i    (cmp),
    .cnt_i    (cnt_i),
    .rdata_o  (bus_rdata)
  );

  // R1
  rst_clr_chk: assert property (@(posedge clk)
    rst |=> (!irq && bus_rdata == '0 && cmp == '0 && !ctrl.en && !ctrl.mask));

endmodule

// File: tb/tb_cmp_downcount_timer.sv
`timescale 1ns/1ps
module tb_cmp_downcount_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cmp_downcount_timer dut (
    .clk(clk), .rst(rst), .cnt_i(cnt), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam int NV = 6;
  localparam logic [63:0] V_C0 [NV] = '{64'd100, 64'd100, 64'd1000,
    64'h0000_0001_0000_0000, 64'h0000_0002_0000_0010, 64'hFFFF_FFFF_FFFF_FFF0};
  localparam logic [31:0] V_W [NV] = '{32'd50, 32'd50, 32'hFFFF_FFF6,
    32'h7FFF_FFFF, 32'hFFFF_FFE0, 32'h0000_0020};
  localparam logic [63:0] V_C1 [NV] = '{64'd120, 64'd150, 64'd1000,
    64'h0000_0001_0000_0000, 64'h0000_0002_0000_0010, 64'hFFFF_FFFF_FFFF_FFF0};
  localparam logic [63:0] V_CMP [NV] = '{64'h96, 64'h96, 64'h3DE,
    64'h0000_0001_7FFF_FFFF, 64'h0000_0001_FFFF_FFF0, 64'h10};
  localparam logic [31:0] V_TV [NV] = '{32'd30, 32'd0, 32'hFFFF_FFF6,
    32'h7FFF_FFFF, 32'hFFFF_FFE0, 32'h0000_0020};
  localparam logic V_FIRE [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic setcnt(input logic [63:0] v);
    @(negedge clk);
    cnt = v;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {63'd0, irq}, 64'd0);
    rd(2'd0, d); chk("R1 ctrl", {32'd0, d}, 64'd0);
    rd(2'd1, d); chk("R1 cmp lo", {32'd0, d}, 64'd0);
    rd(2'd2, d); chk("R1 cmp hi", {32'd0, d}, 64'd0);

    // vector table: enabled, unmasked
    wr(2'd0, 32'd1);
    for (int i = 0; i < NV; i++) begin
      setcnt(V_C0[i]);
      wr(2'd3, V_W[i]);                                   // R4
      setcnt(V_C1[i]);
      rd(2'd3, d); chk("R5 view", {32'd0, d}, {32'd0, V_TV[i]});
      rd(2'd0, d); chk("R6 status", {32'd0, d}, {61'd0, V_FIRE[i], 2'b01});
      chk("R8 irq", {63'd0, irq}, {63'd0, V_FIRE[i]});
      rd(2'd1, d); chk("R4 cmp lo", {32'd0, d}, {32'd0, V_CMP[i][31:0]});
      rd(2'd2, d); chk("R4 cmp hi", {32'd0, d}, {32'd0, V_CMP[i][63:32]});
    end

    // R7 / R5: disabled, count passes compare, view keeps decreasing
    wr(2'd0, 32'd0);
    setcnt(64'd500);
    wr(2'd3, 32'd100);
    setcnt(64'd550);
    rd(2'd3, d); chk("R5 view disabled", {32'd0, d}, 64'd50);
    setcnt(64'd700);
    rd(2'd3, d); chk("R5 view disabled past", {32'd0, d}, 64'h0000_0000_FFFF_FF9C);
    rd(2'd0, d); chk("R7 status off", {32'd0, d}, 64'd0);
    chk("R7 irq off", {63'd0, irq}, 64'd0);

    // R2 status bit ignores writes
    wr(2'd0, 32'hFFFF_FFFC);
    rd(2'd0, d); chk("R2 status ro", {32'd0, d}, 64'd0);

    // R8 mask suppresses irq, status still set
    wr(2'd0, 32'd3);
    rd(2'd0, d); chk("R2 ctrl masked", {32'd0, d}, 64'd7);
    chk("R8 masked irq", {63'd0, irq}, 64'd0);
    wr(2'd0, 32'd1);
    chk("R8 irq latency", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R8 irq rises", {63'd0, irq}, 64'd1);

    // R3 direct half writes, R6 equality boundary
    wr(2'd1, 32'h0000_1000);
    wr(2'd2, 32'h0000_0001);
    @(negedge clk);
    chk("R6 below irq", {63'd0, irq}, 64'd0);
    rd(2'd1, d); chk("R3 lo", {32'd0, d}, 64'h1000);
    rd(2'd2, d); chk("R3 hi", {32'd0, d}, 64'h1);
    setcnt(64'h0000_0001_0000_0FFF);
    @(negedge clk);
    chk("R6 one below", {63'd0, irq}, 64'd0);
    setcnt(64'h0000_0001_0000_1000);
    chk("R8 before edge", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R6 equal fires", {63'd0, irq}, 64'd1);

    // R9 read data holds without a read strobe
    rd(2'd2, d);
    wr(2'd2, 32'h0000_00AB);
    @(negedge clk);
    chk("R9 rdata hold", {32'd0, bus_rdata}, 64'h1);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", {63'd0, irq}, 64'd0);
    rd(2'd0, d); chk("R1 ctrl after reset", {32'd0, d}, 64'd0);
    rd(2'd2, d); chk("R1 cmp hi after reset", {32'd0, d}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule